// File: doc/BRIEF.md
# DMA Host Register Port

This block is the byte-wide host-facing register port of a four-channel DMA controller. A host selects a register with an offset and accesses it with separate read and write strobes. The per-channel 16-bit address and count words are not stored here. They live in an external channel register store. The port reaches that store through a one-cycle load port and a combinational word read port. Both ports are addressed by channel and by a flag that picks the address or the count word.

All 16-bit channel registers are reached one byte at a time through a single shared byte pointer. A clear pointer selects the low byte and a set pointer selects the high byte. The pointer flips after every read or write of a channel register. Software must clear the pointer with a command write before it starts a two-byte access.

The port also holds the control state that belongs to the host side: the channel mask, the terminal-count status bits, the temporary data byte, a per-channel mode byte and the software request bits. Some offsets are write-only commands. These commands clear the pointer, clear the mask, or perform a master clear. Reads at the write-only offsets return all ones.

Top module: `dma_regport`

## Requirements
- R1: Only addr_i[3:0] is decoded; upper address bits have no effect on which register is accessed.
- R2: Offsets 0 to 7 reach channel addr_i[2:1]. An even offset selects the address word (rd_cnt_o/ld_cnt_o = 0) and an odd offset selects the count word (= 1). rd_chan_o and ld_chan_o carry the channel.
- R3: The byte pointer ptr_o resets to 0. A read at offsets 0 to 7 returns rd_word_i[7:0] when ptr_o is 0 and rd_word_i[15:8] when ptr_o is 1. Every read or write at offsets 0 to 7 inverts ptr_o at the end of that cycle. Accesses at offsets 8 to 15 leave it unchanged, apart from the commands in R8 and R10.
- R4: A write at offsets 0 to 7 raises ld_o for that one cycle, with ld_data_o = wdata_i and ld_hi_o equal to the pointer value before the toggle. No other access raises ld_o.
- R5: A read at offset 8 returns {dreq_i[3:0], status_tc[3:0]}. A read at offset 10 returns {4'h0, mask}. A read at offset 13 returns the temporary byte.
- R6: Reads at offsets 9, 11, 12, 14 and 15 return 8'hFF.
- R7: A pulse on tc_i[n] sets terminal-count status bit n. A status read clears all four bits at the end of that cycle. A tc_i bit raised in the same cycle as the read remains set.
- R8: Writing offset 12 clears the pointer. Writing offset 14 clears all mask bits. Writing offset 15 loads the mask from wdata_i[3:0]. Writing offset 10 sets mask bit wdata_i[1:0] to wdata_i[2].
- R9: Writing offset 11 stores wdata_i[7:2] as the mode of channel wdata_i[1:0], at mode_o[6n+5:6n]. Writing offset 9 sets software request bit sreq_o[wdata_i[1:0]] to wdata_i[2].
- R10: Writing offset 13 is a master clear. It clears the pointer, the status bits and the temporary byte, and it sets all mask bits.
- R11: Reset leaves the pointer, status, temporary byte, mode and request bits at zero, and the mask all ones.
- R12: tmp_ld_i loads tmp_i into the temporary byte. A master clear in the same cycle takes precedence.
- R13: When wr_i and rd_i are high together, the access is a write only. No read side effect occurs, so the status bits are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register offset; low 4 bits decoded |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| ld_o | output | 1 | Load strobe to channel store |
| ld_chan_o | output | 2 | Channel to load |
| ld_cnt_o | output | 1 | Load target: 0 address, 1 count |
| ld_hi_o | output | 1 | Load the high byte |
| ld_data_o | output | 8 | Byte to load |
| rd_chan_o | output | 2 | Channel of the word being read |
| rd_cnt_o | output | 1 | Read word: 0 address, 1 count |
| rd_word_i | input | 16 | Current word from channel store |
| tc_i | input | 4 | Terminal-count pulses per channel |
| dreq_i | input | 4 | Live request lines, shown in status |
| tmp_ld_i | input | 1 | Load temporary byte |
| tmp_i | input | 8 | Temporary byte value |
| mask_o | output | 4 | Channel mask |
| sreq_o | output | 4 | Software request bits |
| mode_o | output | 24 | Packed per-channel mode bytes |
| ptr_o | output | 1 | Byte pointer |

## Verification
The hardest state to reach is a pointer mismatch. The pointer is shared by all eight channel registers, so it can be left set by an unrelated register. A following access then lands on the wrong byte without any visible error. The stimulus leaves the pointer set and then reads the write-only offsets. It reads the same register again to show the pointer did not move. It also clears the pointer mid-sequence and confirms that the next read returns the low byte. A second hard case is a terminal-count pulse arriving in the very cycle of a status read. The bench drives tc_i together with the status read strobe and checks that the new bit outlives the clear.

// File: rtl/dma_regport_pkg.sv
package dma_regport_pkg;
  typedef enum logic [3:0] {
    OFS_STATUS   = 4'd8,
    OFS_SREQ     = 4'd9,
    OFS_MASK_ONE = 4'd10,
    OFS_MODE     = 4'd11,
    OFS_CLR_PTR  = 4'd12,
    OFS_MCLR     = 4'd13,
    OFS_CLR_MASK = 4'd14,
    OFS_MASK_ALL = 4'd15
  } ofs_e;

  typedef struct packed {
    logic       chan_acc;
    logic [1:0] chan;
    logic       is_cnt;
    logic [3:0] ofs;
  } dec_t;
endpackage

// File: rtl/dma_regport_decode.sv
module dma_regport_decode
  import dma_regport_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.ofs      = addr_i[3:0];
    dec_o.chan_acc = ~addr_i[3];
    dec_o.chan     = addr_i[2:1];
    dec_o.is_cnt   = addr_i[0];
  end
endmodule

// File: rtl/dma_regport_ctrl.sv
module dma_regport_ctrl
  import dma_regport_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8,
  parameter int MODE_W = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  dec_t                          dec_i,
  input  logic [DW-1:0]                 wdata_i,
  input  logic [NUM_CH-1:0]             tc_i,
  input  logic                          tmp_ld_i,
  input  logic [DW-1:0]                 tmp_i,
  output logic                          ptr_o,
  output logic [NUM_CH-1:0]             mask_o,
  output logic [NUM_CH-1:0]             tc_st_o,
  output logic [DW-1:0]                 tmp_o,
  output logic [NUM_CH-1:0][MODE_W-1:0] mode_o,
  output logic [NUM_CH-1:0]             sreq_o
);
  localparam int CH_W = $clog2(NUM_CH);

  logic rd_eff, chan_hit, cmd_wr, mclr, clr_ptr, st_rd;
  logic [CH_W-1:0] wsel;

  assign rd_eff   = rd_i & ~wr_i;   // write wins when both strobes are high
  assign chan_hit = dec_i.chan_acc & (rd_eff | wr_i);
  assign cmd_wr   = wr_i & ~dec_i.chan_acc;
  assign mclr     = cmd_wr & (dec_i.ofs == OFS_MCLR);
  assign clr_ptr  = cmd_wr & (dec_i.ofs == OFS_CLR_PTR);
  assign st_rd    = rd_eff & (dec_i.ofs == OFS_STATUS);
  assign wsel     = wdata_i[CH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_o <= 1'b0;
    else if (mclr || clr_ptr)   ptr_o <= 1'b0;
    else if (chan_hit)          ptr_o <= ~ptr_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '1;
    else if (cmd_wr) begin
      unique case (dec_i.ofs)
        OFS_MCLR:     mask_o <= '1;
        OFS_CLR_MASK: mask_o <= '0;
        OFS_MASK_ALL: mask_o <= wdata_i[NUM_CH-1:0];
        OFS_MASK_ONE: mask_o[wsel] <= wdata_i[2];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tc_st_o <= '0;
    else if (mclr)  tc_st_o <= '0;
    else if (st_rd) tc_st_o <= tc_i;
    else            tc_st_o <= tc_st_o | tc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tmp_o <= '0;
    else if (mclr)     tmp_o <= '0;
    else if (tmp_ld_i) tmp_o <= tmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      sreq_o <= '0;
    end else if (cmd_wr) begin
      if (dec_i.ofs == OFS_MODE) mode_o[wsel] <= wdata_i[DW-1:DW-MODE_W];
      if (dec_i.ofs == OFS_SREQ) sreq_o[wsel] <= wdata_i[2];
    end
  end

  // R3
  ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_hit |=> ptr_o != $past(ptr_o));
  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_hit && !mclr && !clr_ptr |=> $stable(ptr_o));
  // R10
  mclr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr |=> mask_o == '1 && !ptr_o && tc_st_o == '0 && tmp_o == '0);
  // R7
  st_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rd && tc_i == '0 |=> tc_st_o == '0);
  // R13
  st_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !mclr |=> (tc_st_o & $past(tc_st_o)) == $past(tc_st_o));
endmodule

// File: rtl/dma_regport.sv
module dma_regport
  import dma_regport_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 4,
  parameter int DW     = 8,
  parameter int MODE_W = 6,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int WW    = 2 * DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 ld_o,
  output logic [CH_W-1:0]      ld_chan_o,
  output logic                 ld_cnt_o,
  output logic                 ld_hi_o,
  output logic [DW-1:0]        ld_data_o,
  output logic [CH_W-1:0]      rd_chan_o,
  output logic                 rd_cnt_o,
  input  logic [WW-1:0]        rd_word_i,
  input  logic [NUM_CH-1:0]    tc_i,
  input  logic [NUM_CH-1:0]    dreq_i,
  input  logic                 tmp_ld_i,
  input  logic [DW-1:0]        tmp_i,
  output logic [NUM_CH-1:0]    mask_o,
  output logic [NUM_CH-1:0]    sreq_o,
  output logic [NUM_CH*MODE_W-1:0] mode_o,
  output logic                 ptr_o
);
  dec_t dec;
  logic [NUM_CH-1:0] tc_st;
  logic [DW-1:0] tmp_q;
  logic [NUM_CH-1:0][MODE_W-1:0] mode_q;

  dma_regport_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(addr_i), .dec_o(dec));

  dma_regport_ctrl #(.NUM_CH(NUM_CH), .DW(DW), .MODE_W(MODE_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .rd_i, .dec_i(dec), .wdata_i, .tc_i,
    .tmp_ld_i, .tmp_i, .ptr_o, .mask_o, .tc_st_o(tc_st), .tmp_o(tmp_q),
    .mode_o(mode_q), .sreq_o
  );

  assign mode_o    = mode_q;
  assign rd_chan_o = dec.chan;
  assign rd_cnt_o  = dec.is_cnt;
  assign ld_chan_o = dec.chan;
  assign ld_cnt_o  = dec.is_cnt;
  assign ld_o      = wr_i & dec.chan_acc;
  assign ld_hi_o   = ptr_o;
  assign ld_data_o = wdata_i;

  always_comb begin
    rdata_o = '1;
    if (dec.chan_acc) rdata_o = ptr_o ? rd_word_i[WW-1:DW] : rd_word_i[DW-1:0];
    else begin
      case (dec.ofs)
        OFS_STATUS:   rdata_o = {dreq_i, tc_st};
        OFS_MASK_ONE: rdata_o = {{(DW-NUM_CH){1'b0}}, mask_o};
        OFS_MCLR:     rdata_o = tmp_q;
        default:      rdata_o = '1;
      endcase
    end
  end

  // R4
  ld_only_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |-> wr_i && addr_i[3] == 1'b0);
  // R6
  wo_read_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i[3] && (addr_i[2:0] inside {3'd1, 3'd3, 3'd4, 3'd6, 3'd7})
    |-> rdata_o == 8'hFF);
endmodule

// File: tb/dma_regport_test.sv
module dma_regport_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, tmp_in = 0;
  logic rd = 0, wr = 0, tmp_ld = 0;
  logic [3:0] tc = 0, dreq = 0;
  logic [7:0] rdata, ld_data;
  logic ld, ld_cnt, ld_hi, rd_cnt, ptr;
  logic [1:0] ld_chan, rd_chan;
  logic [15:0] rd_word;
  logic [3:0] mask, sreq;
  logic [23:0] mode;
  logic [15:0] store [8];
  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regport uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .ld_o(ld), .ld_chan_o(ld_chan),
    .ld_cnt_o(ld_cnt), .ld_hi_o(ld_hi), .ld_data_o(ld_data),
    .rd_chan_o(rd_chan), .rd_cnt_o(rd_cnt), .rd_word_i(rd_word), .tc_i(tc),
    .dreq_i(dreq), .tmp_ld_i(tmp_ld), .tmp_i(tmp_in), .mask_o(mask),
    .sreq_o(sreq), .mode_o(mode), .ptr_o(ptr)
  );

  // channel store model
  assign rd_word = store[{rd_chan, rd_cnt}];
  always @(posedge clk)
    if (ld) begin
      if (ld_hi) store[{ld_chan, ld_cnt}][15:8] <= ld_data;
      else       store[{ld_chan, ld_cnt}][7:0]  <= ld_data;
    end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(logic w, logic r, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr = 0; rd = 0; tc = 0; tmp_ld = 0;
  endtask

  typedef struct packed {
    logic w, r, c;
    logic [7:0] a, d, e;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{1,0,0,8'h00,8'h34,8'h00}, '{1,0,0,8'h00,8'h12,8'h00},
    '{0,1,1,8'h00,8'h00,8'h34}, '{0,1,1,8'h00,8'h00,8'h12},
    '{1,0,0,8'h07,8'hCD,8'h00}, '{1,0,0,8'h07,8'hAB,8'h00},
    '{0,1,1,8'h17,8'h00,8'hCD}, '{0,1,1,8'h07,8'h00,8'hAB},
    '{1,0,0,8'h05,8'h55,8'h00}, '{1,0,0,8'h0C,8'h00,8'h00},
    '{0,1,1,8'h05,8'h00,8'h55}, '{0,1,1,8'h09,8'h00,8'hFF},
    '{0,1,1,8'h0B,8'h00,8'hFF}, '{0,1,1,8'h0C,8'h00,8'hFF},
    '{0,1,1,8'h0E,8'h00,8'hFF}, '{0,1,1,8'h0F,8'h00,8'hFF},
    '{0,1,1,8'h05,8'h00,8'h00}, '{0,1,1,8'h0A,8'h00,8'h0F},
    '{1,0,0,8'h0E,8'h00,8'h00}, '{0,1,1,8'h0A,8'h00,8'h00},
    '{1,0,0,8'h0A,8'h06,8'h00}, '{0,1,1,8'h0A,8'h00,8'h04},
    '{1,0,0,8'h0F,8'h09,8'h00}, '{0,1,1,8'h0A,8'h00,8'h09}
  };

  initial begin
    #(CLK_PERIOD * 5000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) store[i] = 16'h0000;
    #(CLK_PERIOD * 2 + 2);
    // R11 reset state
    chk("R11 ptr", ptr, 0); chk("R11 mask", mask, 4'hF);
    chk("R11 mode/sreq", {mode, sreq}, 0);
    rst_n = 1;
    addr = 8'h08; rd = 1; #1;
    chk("R11 status", rdata, 8'h00);
    addr = 8'h0D; #1;
    chk("R11 temp", rdata, 8'h00);
    rd = 0;

    // R1 R2 R3 R5 R6 R8 via table
    for (int i = 0; i < NV; i++) begin
      acc(VT[i].w, VT[i].r, VT[i].a, VT[i].d);
      #1;
      if (VT[i].c) chk($sformatf("R3/R5/R6/R8 vec%0d", i), rdata, VT[i].e);
    end
    idle();

    // R2 R4 load port fields
    acc(1, 0, 8'h0C, 0); idle();
    acc(1, 0, 8'h13, 8'h77); #1;
    chk("R4 ld fields", {ld, ld_chan, ld_cnt, ld_hi, ld_data}, {1'b1, 2'd1, 1'b1, 1'b0, 8'h77});
    acc(0, 1, 8'h04, 0); #1;
    chk("R2 rd select", {rd_chan, rd_cnt}, {2'd2, 1'b0});
    chk("R4 no ld on read", ld, 0);
    idle(); #1;
    chk("R3 ptr after two acc", ptr, 0);

    // R7 status set and clear
    dreq = 4'hA;
    @(negedge clk); tc = 4'b0101;
    idle();
    acc(0, 1, 8'h08, 0); #1;
    chk("R7 status set", rdata, 8'hA5);
    idle();
    acc(0, 1, 8'h08, 0); #1;
    chk("R7 status cleared", rdata, 8'hA0);
    tc = 4'b0010;
    idle();
    acc(0, 1, 8'h08, 0); #1;
    chk("R7 tc same cycle kept", rdata, 8'hA2);
    // R13 write and read together: no clear
    @(negedge clk); tc = 4'b1000; rd = 0;
    idle();
    acc(1, 1, 8'h08, 0);
    idle();
    acc(0, 1, 8'h08, 0); #1;
    chk("R13 no read side effect", rdata, 8'hA8);
    idle();

    // R12 temporary load
    @(negedge clk); tmp_ld = 1; tmp_in = 8'h5A;
    idle();
    acc(0, 1, 8'h0D, 0); #1;
    chk("R12 temp load", rdata, 8'h5A);

    // R9 mode and request
    acc(1, 0, 8'h0B, 8'b1011_0110);
    acc(1, 0, 8'h09, 8'h07);
    idle(); #1;
    chk("R9 mode ch2", mode[17:12], 6'b101101);
    chk("R9 other modes", {mode[23:18], mode[11:0]}, 0);
    chk("R9 sreq", sreq, 4'b1000);

    // R10 master clear
    acc(1, 0, 8'h0E, 0);
    acc(1, 0, 8'h01, 8'h11);
    @(negedge clk); tc = 4'h3; wr = 0; rd = 0;
    idle(); #1;
    chk("R10 pre ptr", ptr, 1);
    acc(1, 0, 8'h0D, 0);
    @(negedge clk); tmp_ld = 0; wr = 0; #1;
    chk("R10 ptr/mask", {ptr, mask}, {1'b0, 4'hF});
    acc(0, 1, 8'h08, 0); #1;
    chk("R10 status", rdata, 8'hA0);
    acc(0, 1, 8'h0D, 0); #1;
    chk("R10 temp", rdata, 8'h00);
    idle();

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule